// File: doc/BRIEF.md
# Lockable Thermal Trip Register Block

This block is the register front end of an on-die thermal monitor. Firmware programs a critical temperature limit, a calibration slope and a shutdown enable over a simple synchronous register bus. Each valid raw sensor sample is scaled by the slope into degrees Centigrade, and the result is exposed as a read-only current temperature. When that temperature is above the limit and shutdown is enabled, a sticky shutdown request is raised for the power sequencer.

A single write-once lock guards every control that can change detection or response: the limit, the slope and the shutdown enable. Once firmware sets it, software can no longer move the trip point, skew the conversion or disarm the response. Only a system reset reopens the registers.

Top module: `therm_guard_top`

## Requirements
- R1: After a synchronous active-low reset the limit reads 125, the slope reads 25, the lock reads 0, the shutdown control reads 0, the current temperature reads 0 and the shutdown output is 0.
- R2: While unlocked, a write at offset 0x00 stores data bits [7:0] as the limit (bits [31:8] read 0), a write at 0x04 stores all 32 bits as the slope, and a write at 0x0C stores data bit 1 as the shutdown enable, read back at bit 1 with every other bit 0.
- R3: A write at offset 0x08 with data bit 0 equal to 1 sets the lock, read back at bit 0 with bits [31:1] 0; a write with bit 0 equal to 0 never clears it, and only reset does.
- R4: While the lock is 1, writes at offsets 0x00, 0x04 and 0x0C leave the limit, slope and shutdown enable unchanged.
- R5: In the cycle after a sample-valid strobe, the current temperature equals (raw sample × slope) shifted right by 4, saturated at 255; without a strobe it holds.
- R6: The current temperature at offset 0x10 (bits [7:0]) ignores bus writes.
- R7: The shutdown output rises in the cycle after the current temperature is strictly greater than the limit while the shutdown enable is 1; equality does not trip.
- R8: Once high, the shutdown output stays high until reset, whatever later happens to temperature, limit or enable.
- R9: Reads at any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| smp_valid | input | 1 | Raw sample is valid this cycle |
| smp_raw | input | 8 | Raw sensor sample |
| shutdown_o | output | 1 | Sticky thermal shutdown request |

## Verification
Assertions check every cycle that a set lock never clears and freezes the limit, slope and enable, that the temperature holds without a strobe, and that the shutdown output is sticky, rises only after a real over-limit condition and never misses one. Only the bench scenarios show the exact register values after reset and writes, the saturation arithmetic, the strict comparison at equality, the masking of reserved bits and that a zero write or an unmapped write is harmless, since those depend on particular data patterns checked against the reference model.

// File: rtl/therm_guard_pkg.sv
// Package: shared register offsets and select type for the thermal guard.
// Assumes byte addressing with word-aligned registers.
package therm_guard_pkg;
    localparam int OFS_LIMIT = 'h00;
    localparam int OFS_SLOPE = 'h04;
    localparam int OFS_LOCK  = 'h08;
    localparam int OFS_CTRL  = 'h0C;
    localparam int OFS_TEMP  = 'h10;
    localparam int EN_BIT    = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LIMIT,
        SEL_SLOPE,
        SEL_LOCK,
        SEL_CTRL,
        SEL_TEMP
    } reg_sel_e;
endpackage

// File: rtl/therm_convert.sv
// Converts a raw sample to degrees: raw * slope >> FRAC_SH, saturated to
// TEMP_W bits. Result registered on each valid strobe, held otherwise.
module therm_convert #(
    parameter int DATA_W  = 32,
    parameter int TEMP_W  = 8,
    parameter int FRAC_SH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_raw,
    input  logic [DATA_W-1:0] slope,
    output logic [TEMP_W-1:0] cur_temp
);
    localparam int PROD_W = DATA_W + TEMP_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [TEMP_W-1:0] sat_val;

    // Scale the sample and clamp to the temperature range.
    always_comb begin
        prod    = {{DATA_W{1'b0}}, smp_raw} * {{TEMP_W{1'b0}}, slope};
        scaled  = prod >> FRAC_SH;
        sat_val = (|scaled[PROD_W-1:TEMP_W]) ? {TEMP_W{1'b1}} : scaled[TEMP_W-1:0];
    end

    // Capture the converted value when a sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)         cur_temp <= '0;
        else if (smp_valid) cur_temp <= sat_val;
    end

    // R5
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(cur_temp));
endmodule

// File: rtl/therm_trip.sv
// Sticky shutdown request: set when temperature is strictly above the
// limit with the enable set; cleared only by reset.
module therm_trip #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] cur_temp,
    input  logic [TEMP_W-1:0] limit,
    input  logic              trip_en,
    output logic              shutdown
);
    logic over;

    // Strict over-limit detection gated by the enable.
    always_comb over = trip_en && (cur_temp > limit);

    // Latch the request until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    shutdown <= 1'b0;
        else if (over) shutdown <= 1'b1;
    end

    // R8
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> shutdown);
    // R7
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> $past(trip_en && (cur_temp > limit)));
    // R7
    trip_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_en && (cur_temp > limit)) |=> shutdown);
endmodule

// File: rtl/therm_ctrl_regs.sv
// Control register file: limit, slope, lock and shutdown enable, plus the
// read mux. The lock is write-1-to-set and freezes every detection and
// response control. Assumes one bus access per cycle.
module therm_ctrl_regs
    import therm_guard_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int TEMP_W    = 8,
    parameter int LIMIT_RST = 125,
    parameter int SLOPE_RST = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [TEMP_W-1:0] cur_temp,
    output logic [TEMP_W-1:0] limit,
    output logic [DATA_W-1:0] slope,
    output logic              trip_en
);
    reg_sel_e sel;
    logic     lock_q;
    logic     open_wr;

    // Decode the offset into a register select.
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_LIMIT): sel = SEL_LIMIT;
            ADDR_W'(OFS_SLOPE): sel = SEL_SLOPE;
            ADDR_W'(OFS_LOCK):  sel = SEL_LOCK;
            ADDR_W'(OFS_CTRL):  sel = SEL_CTRL;
            ADDR_W'(OFS_TEMP):  sel = SEL_TEMP;
            default:            sel = SEL_NONE;
        endcase
    end

    // Writes to guarded controls are allowed only while unlocked.
    always_comb open_wr = bus_we && !lock_q;

    // Guarded control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit   <= TEMP_W'(LIMIT_RST);
            slope   <= DATA_W'(SLOPE_RST);
            trip_en <= 1'b0;
        end else if (open_wr) begin
            if (sel == SEL_LIMIT) limit   <= bus_wdata[TEMP_W-1:0];
            if (sel == SEL_SLOPE) slope   <= bus_wdata;
            if (sel == SEL_CTRL)  trip_en <= bus_wdata[EN_BIT];
        end
    end

    // Write-once lock; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       lock_q <= 1'b0;
        else if (bus_we && sel == SEL_LOCK && bus_wdata[0]) lock_q <= 1'b1;
    end

    // Read mux with reserved bits forced to zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_LIMIT: bus_rdata[TEMP_W-1:0] = limit;
            SEL_SLOPE: bus_rdata             = slope;
            SEL_LOCK:  bus_rdata[0]          = lock_q;
            SEL_CTRL:  bus_rdata[EN_BIT]     = trip_en;
            SEL_TEMP:  bus_rdata[TEMP_W-1:0] = cur_temp;
            default:   bus_rdata             = '0;
        endcase
    end

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R4
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(limit) && $stable(slope) && $stable(trip_en)));
    // R3
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(bus_we && bus_addr == ADDR_W'(OFS_LOCK) && bus_wdata[0]));
endmodule

// File: rtl/therm_guard_top.sv
// Top of the lockable thermal guard: register file, sample conversion and
// sticky trip. The analog sensor and power sequencing sit outside.
module therm_guard_top #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int TEMP_W    = 8,
    parameter int FRAC_SH   = 4,
    parameter int LIMIT_RST = 125,
    parameter int SLOPE_RST = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_raw,
    output logic              shutdown_o
);
    logic [TEMP_W-1:0] cur_temp;
    logic [TEMP_W-1:0] limit;
    logic [DATA_W-1:0] slope;
    logic              trip_en;

    therm_ctrl_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TEMP_W(TEMP_W),
        .LIMIT_RST(LIMIT_RST), .SLOPE_RST(SLOPE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_temp(cur_temp), .limit(limit),
        .slope(slope), .trip_en(trip_en)
    );

    therm_convert #(
        .DATA_W(DATA_W), .TEMP_W(TEMP_W), .FRAC_SH(FRAC_SH)
    ) u_conv (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(smp_valid), .smp_raw(smp_raw),
        .slope(slope), .cur_temp(cur_temp)
    );

    therm_trip #(
        .TEMP_W(TEMP_W)
    ) u_trip (
        .clk(clk), .rst_n(rst_n),
        .cur_temp(cur_temp), .limit(limit),
        .trip_en(trip_en), .shutdown(shutdown_o)
    );
endmodule

// File: tb/therm_guard_top_tb.sv
`timescale 1ns/1ps
module therm_guard_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_raw = '0;
    logic        shutdown_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference model state
    int          m_limit, m_temp;
    logic [31:0] m_slope;
    bit          m_lock, m_en, m_sd;

    always #2 clk = ~clk;

    therm_guard_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
        .smp_raw(smp_raw), .shutdown_o(shutdown_o)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return 32'(m_limit);
            8'h04: return m_slope;
            8'h08: return {31'b0, m_lock};
            8'h0C: return {30'b0, m_en, 1'b0};
            8'h10: return 32'(m_temp);
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_reset();
        m_limit = 125; m_slope = 32'd25; m_lock = 0; m_en = 0; m_temp = 0; m_sd = 0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, advance the model.
    task automatic step(input string tag, input logic [7:0] a, input bit w,
                        input logic [31:0] d, input bit v, input logic [7:0] r);
        longint prod;
        int     nt;
        bit     nsd;
        @(negedge clk);
        bus_addr = a; bus_we = w; bus_wdata = d; smp_valid = v; smp_raw = r;
        #1;
        check({tag, " rdata"}, bus_rdata, m_read(a));
        check({tag, " shutdown"}, {31'b0, shutdown_o}, {31'b0, m_sd});
        @(posedge clk);
        nsd  = m_sd || (m_en && (m_temp > m_limit));
        prod = (longint'(r) * longint'(m_slope)) >>> 4;
        nt   = v ? ((prod > 255) ? 255 : int'(prod)) : m_temp;
        if (w && !m_lock) begin
            if (a == 8'h00) m_limit = int'(d[7:0]);
            if (a == 8'h04) m_slope = d;
            if (a == 8'h0C) m_en = d[1];
        end
        if (w && a == 8'h08 && d[0]) m_lock = 1;
        m_temp = nt;
        m_sd   = nsd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_we = 0; smp_valid = 0;
        repeat (2) @(posedge clk);
        m_reset();
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        step(tag, a, 0, 32'h0, 0, 8'h0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        m_reset();
        do_reset();
        // R1 reset values
        rd("R1 limit", 8'h00); rd("R1 slope", 8'h04); rd("R1 lock", 8'h08);
        rd("R1 ctrl", 8'h0C);  rd("R1 temp", 8'h10);
        // R2 unlocked writes, reserved bits masked
        step("R2 limit wr", 8'h00, 1, 32'hFFFF_FF50, 0, 0); rd("R2 limit", 8'h00);
        step("R2 slope wr", 8'h04, 1, 32'h0000_0030, 0, 0); rd("R2 slope", 8'h04);
        step("R2 ctrl wr", 8'h0C, 1, 32'hFFFF_FFFD, 0, 0); rd("R2 ctrl", 8'h0C);
        step("R2 ctrl wr0", 8'h0C, 1, 32'hFFFF_FFFF, 0, 0); rd("R2 ctrl", 8'h0C);
        step("R2 ctrl off", 8'h0C, 1, 32'h0, 0, 0);
        // R6 temperature read-only, R9 unmapped offsets
        step("R6 temp wr", 8'h10, 1, 32'hAB, 0, 0); rd("R6 temp", 8'h10);
        step("R9 wr 0x14", 8'h14, 1, 32'hFFFF_FFFF, 0, 0); rd("R9 rd 0x14", 8'h14);
        step("R9 wr 0x01", 8'h01, 1, 32'h1, 0, 0); rd("R9 rd 0x01", 8'h01);
        rd("R9 rd 0xFC", 8'hFC); rd("R9 lock", 8'h08); rd("R9 limit", 8'h00);
        // R3 zero write to lock ignored
        step("R3 lock wr0", 8'h08, 1, 32'hFFFF_FFFE, 0, 0); rd("R3 lock", 8'h08);
        // R5 conversion, hold and saturation (slope 48)
        step("R5 smp 20", 8'h10, 0, 0, 1, 8'd20); rd("R5 temp", 8'h10);
        rd("R5 hold", 8'h10);
        step("R5 smp 255", 8'h10, 0, 0, 1, 8'd255); rd("R5 sat", 8'h10);
        step("R5 smp 0", 8'h10, 0, 0, 1, 8'd0); rd("R5 zero", 8'h10);
        // R7 equality does not trip: limit 60, raw 20 -> 60
        step("R7 limit", 8'h00, 1, 32'd60, 0, 0);
        step("R7 smp eq", 8'h10, 0, 0, 1, 8'd20);
        step("R7 en", 8'h0C, 1, 32'h2, 0, 0);
        rd("R7 eq", 8'h10); rd("R7 eq", 8'h10);
        // R7 one above trips: raw 21 -> 63
        step("R7 smp gt", 8'h10, 0, 0, 1, 8'd21);
        rd("R7 gt", 8'h10); rd("R7 gt", 8'h10);
        // R8 sticky after cooling and disable
        step("R8 cool", 8'h10, 0, 0, 1, 8'd1);
        step("R8 dis", 8'h0C, 1, 32'h0, 0, 0);
        step("R8 raise", 8'h00, 1, 32'd255, 0, 0);
        rd("R8 hold", 8'h10); rd("R8 hold", 8'h0C);

        // Second session: lock protection
        do_reset();
        rd("R1 sd", 8'h00);
        step("R2 limit", 8'h00, 1, 32'd100, 0, 0);
        step("R2 slope", 8'h04, 1, 32'd16, 0, 0);
        step("R2 en", 8'h0C, 1, 32'h2, 0, 0);
        step("R3 lock set", 8'h08, 1, 32'h1, 0, 0); rd("R3 lock", 8'h08);
        step("R4 limit wr", 8'h00, 1, 32'd250, 0, 0); rd("R4 limit", 8'h00);
        step("R4 slope wr", 8'h04, 1, 32'd1, 0, 0); rd("R4 slope", 8'h04);
        step("R4 ctrl wr", 8'h0C, 1, 32'h0, 0, 0); rd("R4 ctrl", 8'h0C);
        step("R3 lock clr", 8'h08, 1, 32'h0, 0, 0); rd("R3 lock", 8'h08);
        step("R4 smp 100", 8'h10, 0, 0, 1, 8'd100); rd("R4 eq", 8'h10);
        step("R7 smp 101", 8'h10, 0, 0, 1, 8'd101); rd("R7 locked", 8'h10);
        rd("R8 locked", 8'h10);
        do_reset();
        rd("R3 lock after reset", 8'h08); rd("R1 sd clear", 8'h10);
        step("R3 reopened", 8'h00, 1, 32'd7, 0, 0); rd("R3 reopened", 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule